// File: doc/BRIEF.md
# DQS Read-Delay Training Engine

This block trains the read-capture delay of each byte lane of a 16-bit DDR interface. It owns one 5-bit delay code per lane. It issues single-byte test reads over a simple request/response port to an eight-byte training pattern that is already in memory. Each returned byte is judged against the expected pattern byte and against the two error flags of the read path.

For each lane, the engine searches upward from delay 0 for the lower edge of the passing window. It then keeps stepping while all eight bytes still pass, which locates the upper edge. At the end it parks the code midway between the two edges. An optional coarse pass runs first. It sweeps both lanes together until a pair of codes gives two clean reads with no error flags.

A single start pulse launches the whole sequence. A one-cycle done pulse ends it, together with a result flag that reads 0 for OK and 1 for ERROR.

Top module: `dqs_train_engine`

## Requirements
- R1: After reset, every delay code is 0 and busy, done, result_err, rd_req, fifo_rst and flag_clr are all 0.
- R2: Every test read is preceded by one cycle in which fifo_rst and flag_clr are both high. rd_req is high in the next cycle, for exactly one cycle, and at most one read is outstanding. A lane-training read for lane L and pattern index i uses address L + 4*i.
- R3: The expected byte for pattern index i is 0xFE for i = 0 and 0x11*(2i-1) for i = 1..7, giving FE 11 33 55 77 99 BB DD.
- R4: A training read fails if the returned byte differs from the expected byte, or if rsp_masked or rsp_dummy is high with the response.
- R5: Lower-edge search starts the lane at code 0. Any failing read increments the code and restarts the eight-byte pass at index 0. The first code at which all eight bytes pass is recorded as the window start.
- R6: Upper-edge search begins with a full pass at the recorded start code. Each full pass increments the code and repeats the pass. The first failing read stops the scan at the current code.
- R7: After the upper-edge stop, one further fifo_rst pulse is issued without flag_clr and without a read. The lane code is then set to start + ((stop - start) >> 1).
- R8: If either search needs an increment while the lane code is already 31, training ends at once with result_err = 1 and that lane's code left at 31.
- R9: Lanes are trained in order, lane 0 then lane 1. A lane's code keeps its previous value until its own training begins, and a lane after an error is left untouched.
- R10: With coarse_en high at start, the coarse search sweeps lane 0 over 0..31 in the outer loop and lane 1 over 0..31 in the inner loop. For each pair it reads addresses 0 and 1. The sweep stops at the first pair where neither read shows an error flag, and lane training then follows. If no pair is clean, the result is ERROR with both codes at 31.
- R11: start is ignored while busy. done is a one-cycle pulse, and busy falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only when idle |
| coarse_en | input | 1 | Run the coarse two-lane search first |
| rd_req | output | 1 | One-cycle test read request |
| rd_addr | output | 8 | Byte address of the test read |
| rsp_vld | input | 1 | Read response valid |
| rsp_data | input | 8 | Returned byte |
| rsp_masked | input | 1 | Read path flag: data masked |
| rsp_dummy | input | 1 | Read path flag: dummy data |
| fifo_rst | output | 1 | Read FIFO soft reset pulse |
| flag_clr | output | 1 | Clear sticky read flags pulse |
| dly_code | output | 10 | Delay codes, lane L at bits [5L+4:5L] |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle completion pulse |
| result_err | output | 1 | 0 = OK, 1 = ERROR; valid from done onward |

## Verification
fifo_rst and flag_clr rise one clock after the deciding edge, and rd_req follows exactly one clock after them. The response may come at the earliest in the cycle after rd_req, and the engine acts on it at the edge where rsp_vld is high. The final centre load, done, busy falling and result_err all take effect at that same edge or at the centring edge that follows. The bench therefore samples every output at falling edges, answers a request only one falling edge after it sees it, and checks codes and result in the cycle done is seen, then checks once more that done has gone low.

// File: rtl/dqs_train_pkg.sv
package dqs_train_pkg;

  typedef enum logic [1:0] {
    DOP_HOLD,
    DOP_ZERO,
    DOP_INC,
    DOP_LOAD
  } dly_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_ISSUE,
    ST_WAIT,
    ST_CENTER
  } train_st_e;

  typedef enum logic [1:0] {
    PH_COARSE,
    PH_LOWER,
    PH_UPPER
  } train_ph_e;

  // Pattern byte i: 0xFE first, then odd multiples of 0x11.
  function automatic logic [7:0] train_byte(input int unsigned i);
    logic [15:0] prod;
    if (i == 0) return 8'hFE;
    prod = 16'(16'h11 * (2 * i - 1));
    return prod[7:0];
  endfunction

endpackage

// File: rtl/dqs_dly_bank.sv
module dqs_dly_bank
  import dqs_train_pkg::*;
#(
  parameter int NUM_LANES = 2,
  parameter int DLY_W     = 5,
  parameter int LANE_W    = 1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dly_op_e [NUM_LANES-1:0]        op,
  input  logic [DLY_W-1:0]               load_val,
  input  logic [LANE_W-1:0]              sel,
  output logic [NUM_LANES*DLY_W-1:0]     dly_flat,
  output logic [DLY_W-1:0]               sel_dly,
  output logic [NUM_LANES-1:0]           at_max
);

  localparam logic [DLY_W-1:0] DLY_MAX = {DLY_W{1'b1}};

  logic [NUM_LANES-1:0][DLY_W-1:0] dly_arr;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [DLY_W-1:0] code_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
      end else begin
        case (op[g])
          DOP_ZERO: code_q <= '0;
          DOP_INC:  code_q <= code_q + 1'b1;
          DOP_LOAD: code_q <= load_val;
          default:  code_q <= code_q;
        endcase
      end
    end

    assign dly_arr[g]                  = code_q;
    assign dly_flat[g*DLY_W +: DLY_W]  = code_q;
    assign at_max[g]                   = (code_q == DLY_MAX);
  end

  assign sel_dly = dly_arr[sel];

endmodule

// File: rtl/dqs_read_judge.sv
module dqs_read_judge
  import dqs_train_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  input  logic             masked,
  input  logic             dummy,
  input  logic             use_data,
  output logic             fail
);

  logic [7:0] expect_byte;

  always_comb begin
    expect_byte = train_byte(int'(idx));
    fail        = masked | dummy | (use_data && (data != expect_byte));
  end

endmodule

// File: rtl/dqs_train_ctrl.sv
module dqs_train_ctrl
  import dqs_train_pkg::*;
#(
  parameter int NUM_LANES   = 2,
  parameter int DLY_W       = 5,
  parameter int PAT_LEN     = 8,
  parameter int LANE_STRIDE = 4,
  parameter int ADDR_W      = 8,
  parameter int LANE_W      = 1,
  parameter int IDX_W       = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     coarse_en,
  input  logic                     rsp_vld,
  input  logic                     rd_fail,
  input  logic [DLY_W-1:0]         sel_dly,
  input  logic [NUM_LANES-1:0]     at_max,
  output dly_op_e [NUM_LANES-1:0]  op,
  output logic [DLY_W-1:0]         load_val,
  output logic [LANE_W-1:0]        lane,
  output logic [IDX_W-1:0]         idx,
  output logic                     use_data,
  output logic                     rd_req,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     fifo_rst,
  output logic                     flag_clr,
  output logic                     busy,
  output logic                     done,
  output logic                     result_err
);

  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(PAT_LEN - 1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(NUM_LANES - 1);

  train_st_e         st_q, st_n;
  train_ph_e         ph_q, ph_n;
  logic [LANE_W-1:0] lane_q, lane_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DLY_W-1:0]  start_q, start_n;
  logic              err_q, err_n;
  logic [DLY_W-1:0]  span;
  logic [ADDR_W-1:0] addr_n;

  assign span     = sel_dly - start_q;
  assign load_val = start_q + (span >> 1);
  assign lane     = lane_q;
  assign idx      = idx_q;
  assign use_data = (ph_q != PH_COARSE);

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    lane_n  = lane_q;
    idx_n   = idx_q;
    start_n = start_q;
    err_n   = err_q;
    for (int k = 0; k < NUM_LANES; k++) op[k] = DOP_HOLD;

    case (st_q)
      ST_IDLE: begin
        if (start) begin
          err_n  = 1'b0;
          idx_n  = '0;
          lane_n = '0;
          st_n   = ST_CLR;
          op[0]  = DOP_ZERO;
          if (coarse_en) begin
            ph_n  = PH_COARSE;
            op[1] = DOP_ZERO;
          end else begin
            ph_n  = PH_LOWER;
          end
        end
      end

      ST_CLR:   st_n = ST_ISSUE;
      ST_ISSUE: st_n = ST_WAIT;

      ST_WAIT: begin
        if (rsp_vld) begin
          st_n = ST_CLR;
          case (ph_q)
            PH_COARSE: begin
              if (rd_fail) begin
                idx_n = '0;
                if (!at_max[1]) begin
                  op[1] = DOP_INC;
                end else if (!at_max[0]) begin
                  op[0] = DOP_INC;
                  op[1] = DOP_ZERO;
                end else begin
                  err_n = 1'b1;
                  st_n  = ST_IDLE;
                end
              end else if (idx_q == '0) begin
                idx_n = IDX_W'(1);
              end else begin
                ph_n   = PH_LOWER;
                lane_n = '0;
                idx_n  = '0;
                op[0]  = DOP_ZERO;
              end
            end

            PH_LOWER: begin
              if (rd_fail) begin
                idx_n = '0;
                if (at_max[lane_q]) begin
                  err_n = 1'b1;
                  st_n  = ST_IDLE;
                end else begin
                  op[lane_q] = DOP_INC;
                end
              end else if (idx_q == IDX_LAST) begin
                start_n = sel_dly;
                ph_n    = PH_UPPER;
                idx_n   = '0;
              end else begin
                idx_n = idx_q + 1'b1;
              end
            end

            default: begin
              if (rd_fail) begin
                st_n = ST_CENTER;
              end else if (idx_q == IDX_LAST) begin
                idx_n = '0;
                if (at_max[lane_q]) begin
                  err_n = 1'b1;
                  st_n  = ST_IDLE;
                end else begin
                  op[lane_q] = DOP_INC;
                end
              end else begin
                idx_n = idx_q + 1'b1;
              end
            end
          endcase
        end
      end

      ST_CENTER: begin
        op[lane_q] = DOP_LOAD;
        if (lane_q == LANE_LAST) begin
          st_n = ST_IDLE;
        end else begin
          lane_n           = lane_q + 1'b1;
          op[lane_q + 1'b1] = DOP_ZERO;
          ph_n             = PH_LOWER;
          idx_n            = '0;
          st_n             = ST_CLR;
        end
      end

      default: st_n = ST_IDLE;
    endcase
  end

  always_comb begin
    if (ph_n == PH_COARSE) addr_n = ADDR_W'(idx_n);
    else addr_n = ADDR_W'(lane_n) + ADDR_W'(LANE_STRIDE * int'(idx_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      ph_q       <= PH_LOWER;
      lane_q     <= '0;
      idx_q      <= '0;
      start_q    <= '0;
      err_q      <= 1'b0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      fifo_rst   <= 1'b0;
      flag_clr   <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      result_err <= 1'b0;
    end else begin
      st_q       <= st_n;
      ph_q       <= ph_n;
      lane_q     <= lane_n;
      idx_q      <= idx_n;
      start_q    <= start_n;
      err_q      <= err_n;
      rd_req     <= (st_n == ST_ISSUE);
      fifo_rst   <= (st_n == ST_CLR) || (st_n == ST_CENTER);
      flag_clr   <= (st_n == ST_CLR);
      busy       <= (st_n != ST_IDLE);
      done       <= (st_q != ST_IDLE) && (st_n == ST_IDLE);
      result_err <= err_n;
      if (st_n == ST_ISSUE) rd_addr <= addr_n;
    end
  end

endmodule

// File: rtl/dqs_train_engine.sv
module dqs_train_engine
  import dqs_train_pkg::*;
#(
  parameter int NUM_LANES   = 2,
  parameter int DLY_W       = 5,
  parameter int PAT_LEN     = 8,
  parameter int LANE_STRIDE = 4,
  parameter int ADDR_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         coarse_en,
  output logic                         rd_req,
  output logic [ADDR_W-1:0]            rd_addr,
  input  logic                         rsp_vld,
  input  logic [7:0]                   rsp_data,
  input  logic                         rsp_masked,
  input  logic                         rsp_dummy,
  output logic                         fifo_rst,
  output logic                         flag_clr,
  output logic [NUM_LANES*DLY_W-1:0]   dly_code,
  output logic                         busy,
  output logic                         done,
  output logic                         result_err
);

  localparam int LANE_W = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1;
  localparam int IDX_W  = (PAT_LEN > 1) ? $clog2(PAT_LEN) : 1;

  dly_op_e [NUM_LANES-1:0] op;
  logic [DLY_W-1:0]        load_val;
  logic [DLY_W-1:0]        sel_dly;
  logic [NUM_LANES-1:0]    at_max;
  logic [LANE_W-1:0]       lane;
  logic [IDX_W-1:0]        idx;
  logic                    use_data;
  logic                    rd_fail;

  dqs_train_ctrl #(
    .NUM_LANES(NUM_LANES), .DLY_W(DLY_W), .PAT_LEN(PAT_LEN),
    .LANE_STRIDE(LANE_STRIDE), .ADDR_W(ADDR_W), .LANE_W(LANE_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .coarse_en(coarse_en),
    .rsp_vld(rsp_vld), .rd_fail(rd_fail), .sel_dly(sel_dly), .at_max(at_max),
    .op(op), .load_val(load_val), .lane(lane), .idx(idx), .use_data(use_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .fifo_rst(fifo_rst), .flag_clr(flag_clr),
    .busy(busy), .done(done), .result_err(result_err)
  );

  dqs_dly_bank #(
    .NUM_LANES(NUM_LANES), .DLY_W(DLY_W), .LANE_W(LANE_W)
  ) u_bank (
    .clk(clk), .rst(rst), .op(op), .load_val(load_val), .sel(lane),
    .dly_flat(dly_code), .sel_dly(sel_dly), .at_max(at_max)
  );

  dqs_read_judge #(
    .IDX_W(IDX_W)
  ) u_judge (
    .idx(idx), .data(rsp_data), .masked(rsp_masked), .dummy(rsp_dummy),
    .use_data(use_data), .fail(rd_fail)
  );

endmodule

// File: rtl/dqs_train_sva.sv
module dqs_train_sva (
  input logic clk,
  input logic rst,
  input logic rd_req,
  input logic fifo_rst,
  input logic flag_clr,
  input logic busy,
  input logic done,
  input logic result_err
);

  // R2: each read follows a cycle of FIFO reset plus flag clear
  a_r2_clear_precedes_read: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> $past(fifo_rst) && $past(flag_clr));

  // R2: request lasts one cycle
  a_r2_single_request: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R7: the centring FIFO reset is not followed by a read
  a_r7_center_no_read: assert property (@(posedge clk) disable iff (rst)
    (fifo_rst && !flag_clr) |=> !rd_req);

  // R11: done ends a busy period
  a_r11_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));

  // R11: no activity on the read side while idle
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rd_req && !flag_clr);

  // R8: an error result appears only with completion
  a_r8_error_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(result_err) |-> done);

endmodule

bind dqs_train_engine dqs_train_sva u_sva (
  .clk(clk), .rst(rst), .rd_req(rd_req), .fifo_rst(fifo_rst),
  .flag_clr(flag_clr), .busy(busy), .done(done), .result_err(result_err)
);

// File: tb/dqs_train_engine_tb.sv
module dqs_train_engine_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       coarse_en = 1'b0;
  logic       rd_req;
  logic [7:0] rd_addr;
  logic       rsp_vld = 1'b0;
  logic [7:0] rsp_data = 8'h00;
  logic       rsp_masked = 1'b0;
  logic       rsp_dummy = 1'b0;
  logic       fifo_rst, flag_clr;
  logic [9:0] dly_code;
  logic       busy, done, result_err;

  always #4 clk = ~clk;

  dqs_train_engine u_dut (
    .clk(clk), .rst(rst), .start(start), .coarse_en(coarse_en),
    .rd_req(rd_req), .rd_addr(rd_addr), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
    .rsp_masked(rsp_masked), .rsp_dummy(rsp_dummy), .fifo_rst(fifo_rst),
    .flag_clr(flag_clr), .dly_code(dly_code), .busy(busy), .done(done),
    .result_err(result_err)
  );

  int checks = 0;
  int errors = 0;
  int lo_w[2];
  int hi_w[2];
  int crs_c0 = 0, crs_c1 = 0;
  bit crs_rule = 1'b0;
  bit cap_arm = 1'b0, cap_seen = 1'b0;
  int cap_val = 0;
  int exp_d[2] = '{0, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    case (i)
      0: return 8'hFE; 1: return 8'h11; 2: return 8'h33; 3: return 8'h55;
      4: return 8'h77; 5: return 8'h99; 6: return 8'hBB; default: return 8'hDD;
    endcase
  endfunction

  function automatic int lane_d(input int l);
    return int'(dly_code[5*l +: 5]);
  endfunction

  // Memory/read-path model: R3 pattern, R4 failure kinds, R10 coarse flags
  task automatic respond();
    int a, l, i, d;
    bit ok, m, y;
    logic [7:0] dat;
    a = int'(rd_addr);
    l = a % 4;
    i = a / 4;
    d = lane_d(l);
    if (cap_arm && a == 4) begin
      cap_val = lane_d(1);
      cap_seen = 1'b1;
      cap_arm = 1'b0;
    end
    ok = (d >= lo_w[l] && d <= hi_w[l]) || (i != d % 8);
    m = 1'b0; y = 1'b0; dat = pat(i);
    if (!ok) begin
      if (i == 0 || d % 2 == 0) dat = pat(i) ^ 8'h40;
      else if (d % 4 == 1) m = 1'b1;
      else y = 1'b1;
    end
    if (crs_rule && a < 2 && !(lane_d(0) >= crs_c0 && lane_d(1) >= crs_c1)) m = 1'b1;
    @(negedge clk);
    rsp_vld = 1'b1; rsp_data = dat; rsp_masked = m; rsp_dummy = y;
    @(negedge clk);
    rsp_vld = 1'b0; rsp_masked = 1'b0; rsp_dummy = 1'b0;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) respond();
    end
  end

  // R2 monitor: clear cycle before every request, legal address
  bit prev_fr = 1'b0, prev_fc = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req) begin
        chk(prev_fr && prev_fc, "R2 clear before read", int'({prev_fr, prev_fc}), 3);
        chk(rd_addr < 8'd32 && rd_addr[1] == 1'b0, "R2 address L+4i", int'(rd_addr), 0);
      end
      prev_fr = fifo_rst;
      prev_fc = flag_clr;
    end
  end

  function automatic int centre(input int lo, input int hi);
    return lo + ((hi + 1 - lo) >> 1);
  endfunction

  task automatic run_case(input int lo0, input int hi0, input int lo1, input int hi1,
                          input bit crs, input int c0, input int c1, input bit extra);
    bit eerr, tmo;
    int n;
    lo_w[0] = lo0; hi_w[0] = hi0; lo_w[1] = lo1; hi_w[1] = hi1;
    crs_rule = crs; crs_c0 = c0; crs_c1 = c1;
    cap_arm = crs; cap_seen = 1'b0;
    eerr = 1'b0;
    if (crs && c0 > 31) begin
      eerr = 1'b1; exp_d[0] = 31; exp_d[1] = 31;
    end else begin
      for (int l = 0; l < 2; l++) begin
        if (!eerr) begin
          if (lo_w[l] > 31 || hi_w[l] >= 31) begin
            eerr = 1'b1; exp_d[l] = 31;
          end else begin
            exp_d[l] = centre(lo_w[l], hi_w[l]);
          end
        end
      end
    end
    @(negedge clk);
    coarse_en = crs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0; tmo = 1'b0;
    while (!done && !tmo) begin
      @(negedge clk);
      n++;
      // R11: a second start while busy must change nothing
      if (extra && n == 40) start = 1'b1;
      if (extra && n == 41) start = 1'b0;
      if (n > 40000) tmo = 1'b1;
    end
    if (tmo) begin
      chk(1'b0, "watchdog", n, 0);
      return;
    end
    chk(result_err == eerr, "R8 result code", int'(result_err), int'(eerr));
    chk(lane_d(0) == exp_d[0], "R5 R6 R7 lane0 code", lane_d(0), exp_d[0]);
    chk(lane_d(1) == exp_d[1], "R9 R7 lane1 code", lane_d(1), exp_d[1]);
    chk(!busy, "R11 busy low at done", int'(busy), 0);
    if (crs && !eerr) chk(cap_seen && cap_val == c1, "R10 coarse lane1 pick", cap_val, c1);
    @(negedge clk);
    chk(!done, "R11 done one cycle", int'(done), 0);
  endtask

  initial begin
    int los[4] = '{0, 5, 13, 22};
    int ws[3]  = '{0, 3, 8};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dly_code == 10'd0 && !busy && !done && !result_err && !rd_req && !fifo_rst && !flag_clr,
        "R1 reset state", int'(dly_code), 0);
    // R3 R4 R5 R6 R7 sweep of window positions and widths
    for (int a = 0; a < 4; a++) begin
      for (int w = 0; w < 3; w++) begin
        int l1;
        l1 = (los[a] * 3 + 2) % 20;
        run_case(los[a], los[a] + ws[w], l1, l1 + ws[w] + 2, 1'b0, 0, 0, 1'b0);
      end
    end
    run_case(0, 30, 30, 30, 1'b0, 0, 0, 1'b0);      // R6 widest legal windows
    run_case(40, 40, 5, 9, 1'b0, 0, 0, 1'b0);       // R8 R9 lane0 never passes
    run_case(3, 12, 20, 31, 1'b0, 0, 0, 1'b0);      // R8 upper edge at 31
    run_case(31, 31, 2, 4, 1'b0, 0, 0, 1'b0);       // R8 window only at 31
    run_case(7, 15, 9, 19, 1'b0, 0, 0, 1'b1);       // R11 start while busy
    run_case(4, 10, 6, 12, 1'b1, 1, 3, 1'b0);       // R10 coarse success
    run_case(4, 10, 6, 12, 1'b1, 99, 0, 1'b0);      // R10 coarse exhausted
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog global", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule